// File: doc/BRIEF.md
# Integer Execute ALU with Overflow Trap

This block is the integer execute stage of a 32-bit load/store processor. It takes the primary opcode and function field of an instruction together with the operands. These are the value read for the first source register, the value read for the second source register and the 16-bit immediate. It works out the result of every arithmetic, bitwise, compare and upper-immediate instruction that operates on registers or on an immediate. Multiply/divide, shifts, branches and the register file sit outside the block.

The block has one pipeline register. An instruction presented with `in_valid` high on one clock edge produces its result, write enable, destination index and overflow trap in the following cycle. A signed overflow on a trapping add or subtract raises `ovf_trap` and suppresses the register write, so the destination keeps its old contents. Writes that target register 0 are always suppressed.

Top module: `int_exec_alu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `res_valid`, `wr_en`, `ovf_trap`, `wr_addr` and `result` are all zero.
- R2: `res_valid` is the value of `in_valid` sampled one clock earlier. When `res_valid` is low, `wr_en` and `ovf_trap` are low.
- R3: The trapping forms raise `ovf_trap` and drop `wr_en` when the signed 32-bit sum or difference overflows. These forms are register add (opcode 0, funct 32), register subtract (opcode 0, funct 34) and add-immediate (opcode 8).
- R4: The non-trapping forms never raise `ovf_trap` and return the sum or difference modulo 2^32. These forms are opcode 0 with funct 33 (add) or funct 35 (subtract), and opcode 9 (add immediate).
- R5: Opcode 0 with funct 36, 37, 38 or 39 returns rs AND rt, rs OR rt, rs XOR rt or NOT(rs OR rt), in that order.
- R6: Opcodes 12, 13 and 14 (AND, OR, XOR with an immediate) zero-extend the 16-bit immediate before the operation.
- R7: Opcodes 8, 9 and 10 sign-extend the 16-bit immediate by copying its bit 15 into bits 31..16.
- R8: Compares return exactly 1 when rs is below the other operand and 0 otherwise. Funct 42 and opcode 10 compare as signed values. Funct 43 compares as unsigned values.
- R9: Opcode 11 sign-extends the immediate and then compares rs with it as unsigned values.
- R10: Opcode 15 returns the immediate in bits 31..16 and zeros in bits 15..0.
- R11: When `dest` is 0, `wr_en` stays low for every instruction. `wr_addr` carries `dest` of the instruction.
- R12: Any other opcode, or opcode 0 with any other funct, gives `wr_en` low and `ovf_trap` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 6 | Primary opcode field |
| funct | input | 6 | Function field, used when opcode is 0 |
| dest | input | 5 | Destination register index |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| imm | input | 16 | Immediate field |
| res_valid | output | 1 | Registered copy of `in_valid` |
| wr_en | output | 1 | Register write request for the result |
| wr_addr | output | 5 | Destination index for the write |
| result | output | 32 | Computed result |
| ovf_trap | output | 1 | Signed overflow exception on a trapping add or subtract |

## Verification
Any wrong decode, extension or carry choice appears at `result`, `wr_en` or `ovf_trap` in the cycle right after the instruction is issued, because there is only one register stage. The boundary operands 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and 0, run through every operation, expose a swapped signed/unsigned compare, a wrong extension and a missing or spurious overflow within a single issue. A stale or corrupted output register would show as a mismatch against the bench model for the next issued instruction, or as a `res_valid` that does not track the issue strobe.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
   localparam int unsigned OPC_W = 6;
   localparam int unsigned FN_W  = 6;

   localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
   localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
   localparam logic [OPC_W-1:0] OPC_ADDIU = 6'd9;
   localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
   localparam logic [OPC_W-1:0] OPC_SLTIU = 6'd11;
   localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
   localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
   localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
   localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

   localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
   localparam logic [FN_W-1:0] FN_ADDU = 6'd33;
   localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
   localparam logic [FN_W-1:0] FN_SUBU = 6'd35;
   localparam logic [FN_W-1:0] FN_AND  = 6'd36;
   localparam logic [FN_W-1:0] FN_OR   = 6'd37;
   localparam logic [FN_W-1:0] FN_XOR  = 6'd38;
   localparam logic [FN_W-1:0] FN_NOR  = 6'd39;
   localparam logic [FN_W-1:0] FN_SLT  = 6'd42;
   localparam logic [FN_W-1:0] FN_SLTU = 6'd43;

   typedef enum logic [3:0] {
      K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR, K_SLT, K_SLTU, K_LUI
   } alu_kind_e;

   typedef enum logic [1:0] {
      B_REG, B_SEXT, B_ZEXT
   } bsrc_e;

   typedef struct packed {
      alu_kind_e kind;
      bsrc_e     bsrc;
      logic      trap_en;
      logic      legal;
   } alu_ctl_t;
endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
   import int_alu_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   input  logic [FN_W-1:0]  funct,
   output alu_ctl_t         ctl
);
   always_comb begin
      ctl = '{kind: K_NONE, bsrc: B_REG, trap_en: 1'b0, legal: 1'b0};
      unique case (opcode)
         OPC_REG: begin
            ctl.legal = 1'b1;
            unique case (funct)
               FN_ADD:  begin ctl.kind = K_ADD; ctl.trap_en = 1'b1; end
               FN_ADDU: ctl.kind = K_ADD;
               FN_SUB:  begin ctl.kind = K_SUB; ctl.trap_en = 1'b1; end
               FN_SUBU: ctl.kind = K_SUB;
               FN_AND:  ctl.kind = K_AND;
               FN_OR:   ctl.kind = K_OR;
               FN_XOR:  ctl.kind = K_XOR;
               FN_NOR:  ctl.kind = K_NOR;
               FN_SLT:  ctl.kind = K_SLT;
               FN_SLTU: ctl.kind = K_SLTU;
               default: ctl.legal = 1'b0;
            endcase
         end
         OPC_ADDI:  ctl = '{kind: K_ADD,  bsrc: B_SEXT, trap_en: 1'b1, legal: 1'b1};
         OPC_ADDIU: ctl = '{kind: K_ADD,  bsrc: B_SEXT, trap_en: 1'b0, legal: 1'b1};
         OPC_SLTI:  ctl = '{kind: K_SLT,  bsrc: B_SEXT, trap_en: 1'b0, legal: 1'b1};
         OPC_SLTIU: ctl = '{kind: K_SLTU, bsrc: B_SEXT, trap_en: 1'b0, legal: 1'b1};
         OPC_ANDI:  ctl = '{kind: K_AND,  bsrc: B_ZEXT, trap_en: 1'b0, legal: 1'b1};
         OPC_ORI:   ctl = '{kind: K_OR,   bsrc: B_ZEXT, trap_en: 1'b0, legal: 1'b1};
         OPC_XORI:  ctl = '{kind: K_XOR,  bsrc: B_ZEXT, trap_en: 1'b0, legal: 1'b1};
         OPC_LUI:   ctl = '{kind: K_LUI,  bsrc: B_ZEXT, trap_en: 1'b0, legal: 1'b1};
         default:   ctl.legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/int_alu_operand.sv
module int_alu_operand
   import int_alu_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned IMM_W = 16
) (
   input  logic [XLEN-1:0]  rt_val,
   input  logic [IMM_W-1:0] imm,
   input  bsrc_e            bsrc,
   output logic [XLEN-1:0]  b_op
);
   localparam int unsigned EXT_W = XLEN - IMM_W;

   logic [XLEN-1:0] imm_s, imm_z;
   assign imm_s = {{EXT_W{imm[IMM_W-1]}}, imm};
   assign imm_z = {{EXT_W{1'b0}}, imm};

   always_comb begin
      unique case (bsrc)
         B_SEXT:  b_op = imm_s;
         B_ZEXT:  b_op = imm_z;
         default: b_op = rt_val;
      endcase
   end
endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
   import int_alu_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned IMM_W        = 16,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic [XLEN-1:0] a_op,
   input  logic [XLEN-1:0] b_op,
   input  alu_kind_e       kind,
   input  logic            trap_en,
   output logic [XLEN-1:0] res,
   output logic            ovf
);
   localparam int unsigned MSB   = XLEN - 1;
   localparam int unsigned LUI_SH = XLEN - IMM_W;

   logic [XLEN-1:0] arith_sum;
   logic            arith_ovf;
   logic            lt_s, lt_u;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic            do_sub;
         logic [XLEN-1:0] b_x;
         logic [XLEN:0]   wide;
         assign do_sub = (kind == K_SUB) || (kind == K_SLT) || (kind == K_SLTU);
         assign b_x    = do_sub ? ~b_op : b_op;
         assign wide   = {1'b0, a_op} + {1'b0, b_x} + {{XLEN{1'b0}}, do_sub};
         assign arith_sum = wide[XLEN-1:0];
         assign arith_ovf = (a_op[MSB] == b_x[MSB]) && (wide[MSB] != a_op[MSB]);
         assign lt_s = wide[MSB] ^ arith_ovf;
         assign lt_u = ~wide[XLEN];
      end else begin : g_split
         logic [XLEN-1:0] s_add, s_sub;
         logic            o_add, o_sub;
         assign s_add = a_op + b_op;
         assign s_sub = a_op - b_op;
         assign o_add = (a_op[MSB] == b_op[MSB]) && (s_add[MSB] != a_op[MSB]);
         assign o_sub = (a_op[MSB] != b_op[MSB]) && (s_sub[MSB] != a_op[MSB]);
         assign arith_sum = (kind == K_SUB) ? s_sub : s_add;
         assign arith_ovf = (kind == K_SUB) ? o_sub : o_add;
         assign lt_s = $signed(a_op) < $signed(b_op);
         assign lt_u = a_op < b_op;
      end
   endgenerate

   always_comb begin
      unique case (kind)
         K_ADD, K_SUB: res = arith_sum;
         K_AND:        res = a_op & b_op;
         K_OR:         res = a_op | b_op;
         K_XOR:        res = a_op ^ b_op;
         K_NOR:        res = ~(a_op | b_op);
         K_SLT:        res = {{(XLEN-1){1'b0}}, lt_s};
         K_SLTU:       res = {{(XLEN-1){1'b0}}, lt_u};
         K_LUI:        res = b_op << LUI_SH;
         default:      res = '0;
      endcase
   end

   assign ovf = trap_en && ((kind == K_ADD) || (kind == K_SUB)) && arith_ovf;
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
   import int_alu_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned IMM_W        = 16,
   parameter int unsigned RIDX_W       = 5,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [5:0]        opcode,
   input  logic [5:0]        funct,
   input  logic [RIDX_W-1:0] dest,
   input  logic [XLEN-1:0]   rs_val,
   input  logic [XLEN-1:0]   rt_val,
   input  logic [IMM_W-1:0]  imm,
   output logic              res_valid,
   output logic              wr_en,
   output logic [RIDX_W-1:0] wr_addr,
   output logic [XLEN-1:0]   result,
   output logic              ovf_trap
);
   localparam int unsigned HALF = XLEN - IMM_W;

   if (IMM_W >= XLEN) begin : g_bad_imm
      $error("IMM_W must be narrower than XLEN");
   end
   if (RIDX_W < 1) begin : g_bad_ridx
      $error("RIDX_W must be at least 1");
   end

   alu_ctl_t        ctl;
   logic [XLEN-1:0] b_op, core_res;
   logic            core_ovf, wr_ok;

   int_alu_decode u_dec (.opcode(opcode), .funct(funct), .ctl(ctl));

   int_alu_operand #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
      .rt_val(rt_val), .imm(imm), .bsrc(ctl.bsrc), .b_op(b_op));

   int_alu_core #(.XLEN(XLEN), .IMM_W(IMM_W), .SHARED_ADDER(SHARED_ADDER)) u_core (
      .a_op(rs_val), .b_op(b_op), .kind(ctl.kind), .trap_en(ctl.trap_en),
      .res(core_res), .ovf(core_ovf));

   assign wr_ok = in_valid && ctl.legal && (dest != '0) && !core_ovf;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         result    <= '0;
         ovf_trap  <= 1'b0;
      end else begin
         res_valid <= in_valid;
         wr_en     <= wr_ok;
         ovf_trap  <= in_valid && ctl.legal && core_ovf;
         if (in_valid) begin
            wr_addr <= dest;
            result  <= core_res;
         end
      end
   end

   // R2: output strobe tracks the issue strobe one cycle later
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
   a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!wr_en && !ovf_trap));
   // R3: a trap never coexists with a write
   a_r3_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_trap |-> !wr_en);
   // R4: non-trapping encodings never raise the trap
   a_r4_no_trap_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ctl.trap_en) |=> !ovf_trap);
   // R8: compare results are a single bit
   a_r8_compare_bool: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ((ctl.kind == K_SLT) || (ctl.kind == K_SLTU)))
      |=> (result[XLEN-1:1] == '0));
   // R10: upper-immediate leaves the low half clear
   a_r10_lui_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == OPC_LUI) |=> (result[HALF-1:0] == '0));
   // R11: register 0 is never written
   a_r11_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && wr_addr == '0) |-> !wr_en);
endmodule

// File: tb/tb_int_exec_alu.sv
module tb_int_exec_alu;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [5:0]  opcode, funct;
   logic [4:0]  dest;
   logic [31:0] rs_val, rt_val;
   logic [15:0] imm;
   logic        res_valid, wr_en, ovf_trap;
   logic [4:0]  wr_addr;
   logic [31:0] result;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   int_exec_alu dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode), .funct(funct),
      .dest(dest), .rs_val(rs_val), .rt_val(rt_val), .imm(imm),
      .res_valid(res_valid), .wr_en(wr_en), .wr_addr(wr_addr), .result(result),
      .ovf_trap(ovf_trap));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         fails = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // Encoding index 0..17: 8 immediate opcodes, then 10 register functs
   function automatic void enc(input int i, output logic [5:0] o, output logic [5:0] f);
      if (i < 8)       begin o = 6'(8 + i); f = 6'd0; end
      else if (i < 16) begin o = 6'd0; f = 6'(32 + i - 8); end
      else             begin o = 6'd0; f = 6'(42 + i - 16); end
   endfunction

   function automatic string req_of(input logic [5:0] o, input logic [5:0] f);
      case (o)
         6'd8:  return "R3/R7";
         6'd9:  return "R4/R7";
         6'd10: return "R8/R7";
         6'd11: return "R9";
         6'd12, 6'd13, 6'd14: return "R6";
         6'd15: return "R10";
         6'd0: case (f)
            6'd32, 6'd34: return "R3";
            6'd33, 6'd35: return "R4";
            6'd36, 6'd37, 6'd38, 6'd39: return "R5";
            6'd42, 6'd43: return "R8";
            default: return "R12";
         endcase
         default: return "R12";
      endcase
   endfunction

   // Reference model written from the requirements
   function automatic void model(input logic [5:0] o, input logic [5:0] f, input logic [4:0] d,
                                 input logic [31:0] a, input logic [31:0] r, input logic [15:0] im,
                                 output logic legal, output logic we, output logic [31:0] res,
                                 output logic ov);
      logic [31:0] se, ze, b, s;
      logic trap;
      se = {{16{im[15]}}, im};
      ze = {16'h0, im};
      legal = 1'b1; trap = 1'b0; ov = 1'b0; res = '0;
      case (o)
         6'd8:  begin b = se; trap = 1'b1; res = a + b; end
         6'd9:  begin b = se; res = a + b; end
         6'd10: res = {31'd0, $signed(a) < $signed(se)};
         6'd11: res = {31'd0, a < se};
         6'd12: res = a & ze;
         6'd13: res = a | ze;
         6'd14: res = a ^ ze;
         6'd15: res = {im, 16'h0};
         6'd0: case (f)
            6'd32: begin trap = 1'b1; res = a + r; end
            6'd33: res = a + r;
            6'd34: begin trap = 1'b1; res = a - r; end
            6'd35: res = a - r;
            6'd36: res = a & r;
            6'd37: res = a | r;
            6'd38: res = a ^ r;
            6'd39: res = ~(a | r);
            6'd42: res = {31'd0, $signed(a) < $signed(r)};
            6'd43: res = {31'd0, a < r};
            default: legal = 1'b0;
         endcase
         default: legal = 1'b0;
      endcase
      if (trap) begin
         s = res;
         if (o == 6'd0 && f == 6'd34) ov = (a[31] != r[31]) && (s[31] != a[31]);
         else begin
            b = (o == 6'd8) ? se : r;
            ov = (a[31] == b[31]) && (s[31] != a[31]);
         end
      end
      we = legal && !ov && (d != 5'd0);
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Issue at a falling edge, result registered at the next rising edge, sample at next falling edge
   task automatic run_one(input logic [5:0] o, input logic [5:0] f, input logic [4:0] d,
                          input logic [31:0] a, input logic [31:0] r, input logic [15:0] im);
      logic legal, we, ov;
      logic [31:0] res;
      string rq;
      model(o, f, d, a, r, im, legal, we, res, ov);
      rq = (d == 5'd0) ? "R11" : req_of(o, f);
      in_valid = 1'b1; opcode = o; funct = f; dest = d; rs_val = a; rt_val = r; imm = im;
      @(negedge clk);
      in_valid = 1'b0;
      check("R2", "res_valid", 32'(res_valid), 32'd1);
      check(rq, "wr_en", 32'(wr_en), 32'(we));
      check(rq, "ovf_trap", 32'(ovf_trap), 32'(ov));
      check("R11", "wr_addr", 32'(wr_addr), 32'(d));
      if (legal && !ov) check(rq, "result", result, res);
   endtask

   logic [31:0] bnd [4];
   logic [15:0] ibnd [4];

   initial begin
      logic [5:0] o, f;
      void'($urandom(32'd4242));
      bnd[0] = 32'h7FFF_FFFF; bnd[1] = 32'h8000_0000; bnd[2] = 32'hFFFF_FFFF; bnd[3] = 32'h0;
      ibnd[0] = 16'h7FFF; ibnd[1] = 16'h8000; ibnd[2] = 16'hFFFF; ibnd[3] = 16'h0;
      rst_n = 1'b0; in_valid = 1'b1; opcode = 6'd0; funct = 6'd32; dest = 5'd3;
      rs_val = 32'h7FFF_FFFF; rt_val = 32'd1; imm = 16'h0;
      repeat (3) @(negedge clk);
      // R1: reset holds outputs low even with an instruction presented
      check("R1", "reset res_valid", 32'(res_valid), 32'd0);
      check("R1", "reset wr_en", 32'(wr_en), 32'd0);
      check("R1", "reset ovf_trap", 32'(ovf_trap), 32'd0);
      check("R1", "reset result", result, 32'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "post-reset res_valid", 32'(res_valid), 32'd0);
      check("R1", "post-reset wr_addr", 32'(wr_addr), 32'd0);

      // Directed corner cases
      run_one(6'd0, 6'd32, 5'd4, 32'h7FFF_FFFF, 32'd1, 16'h0);        // R3 overflow
      run_one(6'd0, 6'd34, 5'd4, 32'h8000_0000, 32'd1, 16'h0);        // R3 overflow
      run_one(6'd8, 6'd0, 5'd4, 32'h8000_0000, 32'h0, 16'hFFFF);      // R3 overflow
      run_one(6'd0, 6'd33, 5'd4, 32'h7FFF_FFFF, 32'd1, 16'h0);        // R4 wrap
      run_one(6'd11, 6'd0, 5'd4, 32'hFFFF_FFFE, 32'h0, 16'hFFFF);     // R9 -> 1
      run_one(6'd15, 6'd0, 5'd4, 32'hDEAD_BEEF, 32'h0, 16'hABCD);     // R10
      run_one(6'd0, 6'd32, 5'd0, 32'd5, 32'd6, 16'h0);                // R11
      run_one(6'd0, 6'd40, 5'd4, 32'd5, 32'd6, 16'h0);                // R12 bad funct
      run_one(6'd20, 6'd0, 5'd4, 32'd5, 32'd6, 16'h1);                // R12 bad opcode

      // R2: idle cycle produces no result
      @(negedge clk);
      check("R2", "idle res_valid", 32'(res_valid), 32'd0);
      check("R2", "idle wr_en", 32'(wr_en), 32'd0);

      // Boundary operands on every operation
      for (int i = 0; i < 18; i++)
         for (int x = 0; x < 4; x++)
            for (int y = 0; y < 4; y++) begin
               enc(i, o, f);
               run_one(o, f, 5'd7, bnd[x], bnd[y], ibnd[y]);
            end

      // Constrained random: legal encodings mostly, operands biased toward edges
      for (int n = 0; n < 600; n++) begin
         int sel;
         logic [31:0] a, r;
         sel = int'($urandom_range(0, 19));
         if (sel < 18) enc(sel, o, f);
         else begin o = 6'($urandom_range(16, 63)); f = 6'd0; end
         a = ($urandom_range(0, 3) == 0) ? bnd[$urandom_range(0, 3)] : $urandom;
         r = ($urandom_range(0, 3) == 0) ? bnd[$urandom_range(0, 3)] : $urandom;
         run_one(o, f, 5'($urandom_range(0, 31)), a, r, 16'($urandom));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule